// File: doc/BRIEF.md
# Transparent Serial Receive Word Packer

The block takes a raw serial bit stream and, once an external detector reports synchronization, gathers the bits into 16-bit words. It writes each word out to memory through a valid/ready write port. Words land at consecutive addresses inside receive buffers. Each buffer is offered as a descriptor (a base address plus a byte length) over a second valid/ready port. A bit-enable strobe decides which clock cycles carry a bit. The same block therefore serves a continuous serial line and a time-division line where the channel owns only some slots.

After the receiver is enabled it waits in hunt mode. In hunt mode it counts no bits. On synchronization it enters the receiving state and stays there until one of three things happens:
- a word completes with no buffer to hold it (busy),
- carrier detect drops (carrier lost),
- a word completes while the previous write is still unacknowledged (overrun).

Any of these parks the block in a halted state. Only an enter-hunt command, or disabling the receiver, gets it out. Events are sticky flags that are cleared by writing ones, and a mask selects which flags drive the interrupt line.

Back-pressure rules:
- The write port holds `wr_valid`, `wr_addr` and `wr_data` unchanged until `wr_ready` is seen.
- The descriptor port raises `desc_ready` whenever the receiver is hunting or receiving and holds no buffer. A descriptor is taken on the cycle both `desc_valid` and `desc_ready` are high.

Top module: `tsr_packer`

## Requirements
- R1: After reset, `rx_state` is 0 (idle), `wr_valid`, `desc_ready` and `irq` are 0, and all four event flags are 0.
- R2: When `rx_en` rises, the block enters hunt mode (`rx_state`=1). No bit is counted and no write is issued until `sync_ok` is seen high. On that edge it moves to receiving (`rx_state`=2).
- R3: In the receiving state, each counted bit is shifted in MSB first, so the first bit becomes `wr_data[15]`. On the edge that samples the 16th counted bit, a write is issued (`wr_valid` high after that edge).
- R4: A bit is counted only on edges where `bit_en` is high. With 7-bit slots, the word completes on the second bit of the third slot, however long the gaps are.
- R5: The first word of a buffer goes to its base address with bit 0 forced to 0. Each following word goes 2 bytes higher. The buffer length has bit 0 ignored, and a value below 2 counts as 2. After length/2 words the buffer is finished, and the next word needs a new descriptor (`desc_ready` returns high).
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` stay unchanged. Each accepted write sets event bit 0 (word written).
- R7: If a word completes while no buffer is held and no descriptor is offered in that cycle, the block sets event bit 1 (busy), enters the halted state (`rx_state`=3) and issues no write. A descriptor offered in the very cycle the word completes is used for that word, and no busy flag is raised.
- R8: If `cd_ok` is low during the receiving state, the block sets event bit 2 (carrier lost) and halts. During hunt mode, `cd_ok` has no effect.
- R9: If a word completes while the previous write is still unacknowledged, the block sets event bit 3 (overrun) and halts. The new word is discarded, and the pending write's address and data are kept.
- R10: In the halted state no bits are counted and no writes are issued until `hunt_cmd`, which returns the block to hunt mode. `hunt_cmd` also discards any partly assembled word.
- R11: Event flags stay set until a 1 is written on the matching `ev_clr` bit. A flag set in the same cycle as its clear stays set. `irq` is high when any flag is set whose `ev_mask` bit is also set.
- R12: When `rx_en` is low, the block returns to idle (`rx_state`=0) from any state, and `desc_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| sync_ok | input | 1 | Synchronization found by external detector |
| cd_ok | input | 1 | Carrier detect present |
| bit_en | input | 1 | This cycle carries a serial bit |
| bit_in | input | 1 | Serial data bit |
| buf_len | input | 16 | Byte length of the offered buffer |
| desc_valid | input | 1 | Buffer descriptor offered |
| desc_base | input | 16 | Base byte address of the offered buffer |
| desc_ready | output | 1 | Block can take a descriptor |
| wr_valid | output | 1 | Word write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 16 | Byte address of the word |
| wr_data | output | 16 | Assembled word |
| ev_clr | input | 4 | Write-one-to-clear for event flags |
| ev_mask | input | 4 | Interrupt enable per event flag |
| events | output | 4 | Sticky flags: 0 word, 1 busy, 2 carrier lost, 3 overrun |
| irq | output | 1 | Masked OR of event flags |
| rx_state | output | 2 | 0 idle, 1 hunt, 2 receiving, 3 halted |

## Verification
The collision that matters is between word completion and buffer supply. A word can complete in the same cycle that the only available descriptor arrives, and the packer must use that descriptor rather than declare busy. The bench consumes a buffer exactly, then raises `desc_valid` on the edge that samples the sixteenth bit. It judges the result by the new base appearing on `wr_addr` with the busy flag still clear. A second coincidence is also exercised: a write acknowledge and a clear of the word flag in one cycle, where the flag must survive.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_RECV = 2'd2,
    ST_HALT = 2'd3
  } rx_state_e;

  localparam int EV_WORD = 0;
  localparam int EV_BUSY = 1;
  localparam int EV_CDL  = 2;
  localparam int EV_OVR  = 3;
  localparam int EV_N    = 4;
endpackage

// File: rtl/tsr_shifter.sv
module tsr_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_nxt
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  assign word_nxt  = {sh[WORD_W-2:0], bit_in};
  assign word_done = shift_en && (cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= word_nxt;
      cnt <= word_done ? '0 : cnt + 1'b1;
    end
  end

  // R3: a finished word restarts the count for the next one
  p_count_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !clr |=> cnt == '0);

  // R10: a clear leaves nothing assembled
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !word_done);
endmodule

// File: rtl/tsr_bufctl.sv
module tsr_bufctl #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              desc_ready,
  input  logic              accept_word,
  input  logic [WORD_W-1:0] word,
  output logic              hold_ok,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_stall
);
  localparam int STEP = WORD_W / 8;

  logic              have_buf;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] base_al;
  logic [LEN_W-1:0]  len_al, len_eff;
  logic [ADDR_W-1:0] base_eff;
  logic [LEN_W-1:0]  rem_eff;
  logic              take;

  assign base_al  = desc_base & ~ADDR_W'(STEP - 1);
  assign len_al   = buf_len & ~LEN_W'(STEP - 1);
  assign len_eff  = (len_al < LEN_W'(STEP)) ? LEN_W'(STEP) : len_al;

  assign desc_ready = fetch_en && !have_buf;
  assign take       = desc_valid && desc_ready;
  assign hold_ok    = have_buf || take;
  assign base_eff   = have_buf ? cur : base_al;
  assign rem_eff    = have_buf ? rem : len_eff;
  assign wr_stall   = wr_valid && !wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_buf <= 1'b0;
      cur      <= '0;
      rem      <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (accept_word) begin
      wr_valid <= 1'b1;
      wr_addr  <= base_eff;
      wr_data  <= word;
      if (rem_eff == LEN_W'(STEP)) begin
        have_buf <= 1'b0;
      end else begin
        have_buf <= 1'b1;
        cur      <= base_eff + ADDR_W'(STEP);
        rem      <= rem_eff - LEN_W'(STEP);
      end
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (take) begin
        have_buf <= 1'b1;
        cur      <= base_al;
        rem      <= len_eff;
      end
    end
  end

  // R6: a stalled write keeps its contents
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R5: word addresses are always aligned
  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr & ADDR_W'(STEP - 1)) == '0);

  // R9: the controller never stores a word over a stalled write or with no room
  p_accept_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_word |-> hold_ok && !wr_stall);
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            sync_ok,
  input  logic            cd_ok,
  input  logic            hunt_cmd,
  input  logic            bit_en,
  input  logic            word_done,
  input  logic            hold_ok,
  input  logic            wr_stall,
  input  logic            wr_ack,
  input  logic [EV_N-1:0] ev_clr,
  input  logic [EV_N-1:0] ev_mask,
  output rx_state_e       state,
  output logic            shift_en,
  output logic            cnt_clr,
  output logic            accept_word,
  output logic            fetch_en,
  output logic [EV_N-1:0] events,
  output logic            irq
);
  rx_state_e       state_nx;
  logic            in_recv, active;
  logic            cd_drop, ovr_hit, busy_hit;
  logic [EV_N-1:0] ev_set;

  assign in_recv     = (state == ST_RECV);
  assign active      = rx_en && !hunt_cmd && in_recv;
  assign shift_en    = active && cd_ok && bit_en;
  assign cd_drop     = active && !cd_ok;
  assign ovr_hit     = word_done && wr_stall;
  assign busy_hit    = word_done && !wr_stall && !hold_ok;
  assign accept_word = word_done && !wr_stall && hold_ok;
  assign cnt_clr     = !active;
  assign fetch_en    = rx_en && (state == ST_HUNT || state == ST_RECV);

  always_comb begin
    ev_set          = '0;
    ev_set[EV_WORD] = wr_ack;
    ev_set[EV_BUSY] = busy_hit;
    ev_set[EV_CDL]  = cd_drop;
    ev_set[EV_OVR]  = ovr_hit;
  end

  always_comb begin
    state_nx = state;
    if (!rx_en) begin
      state_nx = ST_IDLE;
    end else if (state == ST_IDLE || hunt_cmd) begin
      state_nx = ST_HUNT;
    end else begin
      case (state)
        ST_HUNT: if (sync_ok) state_nx = ST_RECV;
        ST_RECV: if (cd_drop || ovr_hit || busy_hit) state_nx = ST_HALT;
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      events <= '0;
    end else begin
      state  <= state_nx;
      events <= (events & ~ev_clr) | ev_set;
    end
  end

  assign irq = |(events & ev_mask);

  // R12: disabling always returns to idle
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == ST_IDLE);

  // R2: hunt mode waits for synchronization
  p_hunt_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HUNT && rx_en && !hunt_cmd && !sync_ok |=> state == ST_HUNT);

  // R8: carrier loss while receiving halts and flags
  p_cd_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RECV && rx_en && !hunt_cmd && !cd_ok |=> state == ST_HALT && events[EV_CDL]);

  // R7: a word with nowhere to go halts with busy
  p_busy_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !hold_ok && !wr_stall |=> state == ST_HALT && events[EV_BUSY]);

  // R9: a word over a stalled write halts with overrun
  p_ovr_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && wr_stall |=> state == ST_HALT && events[EV_OVR]);

  // R10: halted stays halted until commanded
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT && rx_en && !hunt_cmd |=> state == ST_HALT);

  // R11: flags not cleared stay set
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (events & $past(events & ~ev_clr)) == $past(events & ~ev_clr));
endmodule

// File: rtl/tsr_packer.sv
module tsr_packer
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              hunt_cmd,
  input  logic              sync_ok,
  input  logic              cd_ok,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              desc_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic [EV_N-1:0]   ev_clr,
  input  logic [EV_N-1:0]   ev_mask,
  output logic [EV_N-1:0]   events,
  output logic              irq,
  output logic [1:0]        rx_state
);
  rx_state_e         state;
  logic              shift_en, cnt_clr, accept_word, fetch_en;
  logic              word_done, hold_ok, wr_stall, wr_ack;
  logic [WORD_W-1:0] word_nxt;

  assign wr_ack   = wr_valid && wr_ready;
  assign rx_state = state;

  tsr_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .shift_en  (shift_en),
    .bit_in    (bit_in),
    .word_done (word_done),
    .word_nxt  (word_nxt)
  );

  tsr_bufctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .buf_len     (buf_len),
    .desc_valid  (desc_valid),
    .desc_base   (desc_base),
    .desc_ready  (desc_ready),
    .accept_word (accept_word),
    .word        (word_nxt),
    .hold_ok     (hold_ok),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_stall    (wr_stall)
  );

  tsr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .sync_ok     (sync_ok),
    .cd_ok       (cd_ok),
    .hunt_cmd    (hunt_cmd),
    .bit_en      (bit_en),
    .word_done   (word_done),
    .hold_ok     (hold_ok),
    .wr_stall    (wr_stall),
    .wr_ack      (wr_ack),
    .ev_clr      (ev_clr),
    .ev_mask     (ev_mask),
    .state       (state),
    .shift_en    (shift_en),
    .cnt_clr     (cnt_clr),
    .accept_word (accept_word),
    .fetch_en    (fetch_en),
    .events      (events),
    .irq         (irq)
  );

  // R2: a new write only follows a cycle spent receiving
  p_write_from_recv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(state) == ST_RECV);

  // R12: no descriptor is taken while disabled
  p_no_fetch_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !desc_ready);
endmodule

// File: tb/tb_tsr_packer.sv
`timescale 1ns/1ps
module tb_tsr_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, hunt_cmd = 1'b0, sync_ok = 1'b0, cd_ok = 1'b1;
  logic        bit_en = 1'b0, bit_in = 1'b0;
  logic [15:0] buf_len = '0, desc_base = '0;
  logic        desc_valid = 1'b0, wr_ready = 1'b0;
  logic        desc_ready, wr_valid, irq;
  logic [15:0] wr_addr, wr_data;
  logic [3:0]  ev_clr = '0, ev_mask = '0, events;
  logic [1:0]  rx_state;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tsr_packer dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .hunt_cmd(hunt_cmd),
    .sync_ok(sync_ok), .cd_ok(cd_ok), .bit_en(bit_en), .bit_in(bit_in),
    .buf_len(buf_len), .desc_valid(desc_valid), .desc_base(desc_base),
    .desc_ready(desc_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ev_clr(ev_clr), .ev_mask(ev_mask),
    .events(events), .irq(irq), .rx_state(rx_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(posedge clk); #1 bit_en = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_ok = 1'b1;
    @(posedge clk); #1 sync_ok = 1'b0;
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt_cmd = 1'b1;
    @(posedge clk); #1 hunt_cmd = 1'b0;
  endtask

  task automatic clear_ev();
    @(negedge clk); ev_clr = 4'hF;
    @(posedge clk); #1 ev_clr = 4'h0;
  endtask

  task automatic offer(input logic [15:0] base, input logic [15:0] len);
    @(negedge clk); desc_valid = 1'b1; desc_base = base; buf_len = len;
    while (!desc_ready) @(negedge clk);
    @(posedge clk); #1 desc_valid = 1'b0;
  endtask

  task automatic ack(input logic [3:0] clr);
    @(negedge clk); wr_ready = 1'b1; ev_clr = clr;
    @(posedge clk); #1 wr_ready = 1'b0; ev_clr = 4'h0;
  endtask

  task automatic t_reset();
    check("R1 state", rx_state, 0);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 desc_ready", desc_ready, 0);
    check("R1 events", events, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_hunt();
    @(negedge clk); rx_en = 1'b1;
    @(posedge clk); #1;
    check("R2 hunt entered", rx_state, 1);
    cd_ok = 1'b0;
    send_word(16'hFFFF);
    check("R2 no write in hunt", wr_valid, 0);
    check("R8 carrier ignored in hunt", rx_state, 1);
    check("R8 no cd flag in hunt", events, 0);
    cd_ok = 1'b1;
    pulse_sync();
    check("R2 receiving after sync", rx_state, 2);
  endtask

  task automatic t_basic();
    offer(16'h0101, 16'd5);
    send_word(16'hA5C3);
    check("R3 write after 16 bits", wr_valid, 1);
    check("R3 data msb first", wr_data, 16'hA5C3);
    check("R5 base aligned", wr_addr, 16'h0100);
    repeat (3) @(posedge clk); #1;
    check("R6 held valid", wr_valid, 1);
    check("R6 held data", wr_data, 16'hA5C3);
    check("R6 no flag before accept", events[0], 0);
    ack(4'h0);
    check("R6 write retired", wr_valid, 0);
    check("R6 word flag", events[0], 1);
    send_word(16'h1234);
    check("R5 next address", wr_addr, 16'h0102);
    check("R5 buffer used up", desc_ready, 1);
    ack(4'h1);
    check("R11 set beats clear", events[0], 1);
  endtask

  task automatic t_busy();
    clear_ev();
    send_word(16'hFFFF);
    check("R7 busy flag", events, 4'b0010);
    check("R7 halted", rx_state, 3);
    check("R7 no write", wr_valid, 0);
    send_word(16'h00FF);
    check("R10 halted no write", wr_valid, 0);
    check("R10 still halted", rx_state, 3);
    clear_ev();
    check("R11 cleared", events, 0);
    pulse_hunt();
    check("R10 back to hunt", rx_state, 1);
  endtask

  task automatic t_partial();
    pulse_sync();
    offer(16'h0300, 16'd8);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    pulse_hunt();
    pulse_sync();
    send_word(16'hBEEF);
    check("R10 partial discarded", wr_data, 16'hBEEF);
    check("R10 address", wr_addr, 16'h0300);
    ack(4'h0);
  endtask

  task automatic t_overrun();
    clear_ev();
    send_word(16'h1111);
    check("R9 first write", wr_addr, 16'h0302);
    send_word(16'h2222);
    check("R9 overrun flag", events, 4'b1000);
    check("R9 halted", rx_state, 3);
    check("R9 data kept", wr_data, 16'h1111);
    check("R9 addr kept", wr_addr, 16'h0302);
    ack(4'h0);
    clear_ev();
    pulse_hunt();
    pulse_sync();
  endtask

  task automatic t_cdlost();
    @(negedge clk); cd_ok = 1'b0;
    @(posedge clk); #1 cd_ok = 1'b1;
    check("R8 cd flag", events, 4'b0100);
    check("R8 halted", rx_state, 3);
    @(negedge clk); ev_mask = 4'b0100;
    #1 check("R11 irq masked in", irq, 1);
    ev_mask = 4'b1011;
    #1 check("R11 irq masked out", irq, 0);
    clear_ev();
    pulse_hunt();
    pulse_sync();
  endtask

  task automatic t_same_cycle();
    send_word(16'h7777);
    check("R5 continue buffer", wr_addr, 16'h0304);
    ack(4'h0);
    send_word(16'h8888);
    check("R5 last of buffer", wr_addr, 16'h0306);
    ack(4'h0);
    clear_ev();
    for (int i = 15; i >= 1; i--) send_bit(16'hC0DE >> i);
    @(negedge clk); bit_en = 1'b1; bit_in = 1'b0;
    desc_valid = 1'b1; desc_base = 16'h0400; buf_len = 16'd2;
    @(posedge clk); #1 bit_en = 1'b0; desc_valid = 1'b0;
    check("R7 same cycle write", wr_valid, 1);
    check("R7 same cycle addr", wr_addr, 16'h0400);
    check("R7 same cycle data", wr_data, 16'hC0DE);
    check("R7 no busy", events[1], 0);
    ack(4'h0);
  endtask

  task automatic t_slots();
    logic [15:0] w;
    int k;
    w = 16'h5A0F;
    k = 0;
    offer(16'h0500, 16'd0);
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 7; b++) begin
        if (k < 16) begin
          send_bit(w[15-k]);
          k++;
          if (k == 15) check("R4 not yet", wr_valid, 0);
          if (k == 16) check("R4 slot3 bit2", (s == 2 && b == 1) ? wr_valid : 1'b0, 1);
        end
      end
      repeat (5) @(posedge clk);
      #1;
    end
    check("R4 slot data", wr_data, 16'h5A0F);
    check("R5 short length", desc_ready, 1);
    ack(4'h0);
  endtask

  task automatic t_disable();
    @(negedge clk); rx_en = 1'b0;
    @(posedge clk); #1;
    check("R12 idle", rx_state, 0);
    check("R12 no fetch", desc_ready, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hunt();
    t_basic();
    t_busy();
    t_partial();
    t_overrun();
    t_cdlost();
    t_same_cycle();
    t_slots();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule